// File: doc/BRIEF.md
# Quadrature NCO with FSK, phase and IQ amplitude modulation

This block is the digital core of a direct digital synthesizer. A 32-bit phase accumulator advances by one of two frequency tuning words on every clock. A select pin picks the word each cycle, which gives frequency-shift keying. The tuning word sets the output frequency as the fraction word/2^32 of the clock. A 12-bit phase offset is added to the top of the accumulator to form a table address. One quarter-wave magnitude table serves both the sine and the cosine of that address.

An optional quadrature scaling stage forms a weighted sum of sine and cosine from a signed I/Q pair. The result is a 10-bit offset-binary sample for a current-steering converter. A valid strobe marks samples that came through a full, awake pipeline.

Sleep can come from a pin or from a command bit. Either source freezes the oscillator state and forces the sample code to zero, so the converter draws no current.

Top module: `nco_quad_mod`

## Requirements
- R1: On every active (awake, not clearing) clock edge the accumulator becomes its old value plus `freq0_i` when `fsel_i`=0, or plus `freq1_i` when `fsel_i`=1, modulo 2^32.
- R2: The sample after active edge n is derived from the accumulator value after active edge n-4, so a change of `fsel_i` first shows in the sample four active edges after the edge that samples it.
- R3: The table phase is (accumulator[31:20] + `phase_i`) mod 4096, with `phase_i` sampled three active edges before the sample it affects.
- R4: With `am_en_i`=0 the sample is 512 + 511·sin(2π(p+0.5)/4096) within ±1.5 codes, where p is the table phase. `iq_i` has no effect in this mode.
- R5: With `am_en_i`=1 the sample is 512 + floor((S·I + C·Q)/512), where S and C are the sine and cosine of R4 and cosine is taken at the same phase. I is `iq_i[9:0]` and Q is `iq_i[19:10]`, both two's complement. `am_en_i` and `iq_i` are sampled one active edge before the sample.
- R6: The scaled value is clamped to [-511, +511], so a valid sample code is never 0.
- R7: `acc_clr_i` high at an edge sets the accumulator to zero at that edge, including while asleep.
- R8: While `sleep_i` or `sleep_cmd_i` is high, each edge leaves the accumulator and the pipeline unchanged and drives `sample_o`=0 and `valid_o`=0.
- R9: `valid_o` is 1 only after four active edges since reset or since the last sleeping edge.
- R10: While `rst_ni` is low, `sample_o` and `valid_o` are 0 and the accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq0_i | input | 32 | Tuning word used when fsel_i=0 |
| freq1_i | input | 32 | Tuning word used when fsel_i=1 |
| fsel_i | input | 1 | Per-cycle tuning word select |
| phase_i | input | 12 | Phase offset added to the accumulator top |
| iq_i | input | 20 | Signed I in [9:0], signed Q in [19:10] |
| am_en_i | input | 1 | Enables quadrature scaling |
| acc_clr_i | input | 1 | Synchronous accumulator clear |
| sleep_i | input | 1 | Sleep request from a pin |
| sleep_cmd_i | input | 1 | Sleep request from a command bit |
| sample_o | output | 10 | Offset-binary output sample |
| valid_o | output | 1 | Sample is from a full awake pipeline |

## Verification
The assertions check the per-cycle properties on every cycle. These are the accumulator step under each select value, the clear, the freeze and forced-zero output during sleep, the clamp that keeps valid codes nonzero, and the rule that valid follows an awake edge. Only the bench's scenarios can show the table accuracy and the four-edge alignment between accumulator, phase, I/Q and output. The bench shows these by sweeping every table phase with scaling off, and with several I/Q pairs including saturating ones. It also streams tuning-word toggles, phase steps, clears and sleep episodes against a reference model built on real sine and cosine.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  // Quarter-wave magnitude at half-sample offset, rational sine approximation.
  function automatic int quarter_mag(int idx, int qtr, int peak);
    longint h, u, a, num, den;
    h   = 64'(4 * qtr);
    u   = 64'(2 * idx + 1);
    a   = u * (h - u);
    num = 16 * a * 64'(peak);
    den = 5 * h * h - 4 * a;
    return int'((num + den / 2) / den);
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             fsel_i,
  input  logic [ACC_W-1:0] freq0_i,
  input  logic [ACC_W-1:0] freq1_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [PH_W-1:0]  ph_o
);
  logic [ACC_W-1:0] acc_q, step;
  logic [PH_W-1:0]  ph_q;

  assign step = fsel_i ? freq1_i : freq0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (run_i)  acc_q <= acc_q + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (run_i)  ph_q <= acc_q[ACC_W-1 -: PH_W] + phase_i;
  end

  assign acc_o = acc_q;
  assign ph_o  = ph_q;
endmodule

// File: rtl/nco_sincos_lut.sv
`timescale 1ns/1ps
module nco_sincos_lut #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PH_W-1:0]  ph_i,
  output logic [AMP_W-1:0] sin_o,
  output logic [AMP_W-1:0] cos_o
);
  localparam int QW   = PH_W - 2;
  localparam int QTR  = 1 << QW;
  localparam int PEAK = (1 << (AMP_W - 1)) - 1;

  logic [AMP_W-2:0]            rom [QTR];
  logic [1:0][AMP_W-1:0]       val_d;
  logic [AMP_W-1:0]            sin_q, cos_q;

  for (genvar i = 0; i < QTR; i++) begin : g_rom
    assign rom[i] = (AMP_W-1)'(nco_pkg::quarter_mag(i, QTR, PEAK));
  end

  // channel 0 = sine, channel 1 = cosine (one quadrant ahead)
  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [1:0]       quad;
    logic [QW-1:0]    idx;
    logic [AMP_W-2:0] mag;
    assign quad     = ph_i[PH_W-1 -: 2] + 2'(c);
    assign idx      = quad[0] ? ~ph_i[QW-1:0] : ph_i[QW-1:0];
    assign mag      = rom[idx];
    assign val_d[c] = quad[1] ? (~{1'b0, mag} + AMP_W'(1)) : {1'b0, mag};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_q <= '0;
      cos_q <= '0;
    end else if (run_i) begin
      sin_q <= val_d[0];
      cos_q <= val_d[1];
    end
  end

  assign sin_o = sin_q;
  assign cos_o = cos_q;
endmodule

// File: rtl/nco_am_scale.sv
`timescale 1ns/1ps
module nco_am_scale #(
  parameter int AMP_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               am_en_i,
  input  logic [2*AMP_W-1:0] iq_i,
  input  logic [AMP_W-1:0]   sin_i,
  input  logic [AMP_W-1:0]   cos_i,
  output logic [AMP_W-1:0]   sample_o
);
  localparam int PW   = 2 * AMP_W;
  localparam int MW   = PW + 1;
  localparam int PEAK = (1 << (AMP_W - 1)) - 1;
  localparam logic signed [MW-1:0] HI = MW'(PEAK);
  localparam logic signed [MW-1:0] LO = -HI;

  logic signed [AMP_W-1:0] s_w, c_w, i_w, q_w;
  logic signed [PW-1:0]    p_si, p_cq;
  logic signed [MW-1:0]    mix_d, mix_q, sh, clamped;
  logic [AMP_W-1:0]        code_d, sample_q;

  assign s_w  = $signed(sin_i);
  assign c_w  = $signed(cos_i);
  assign i_w  = $signed(iq_i[AMP_W-1:0]);
  assign q_w  = $signed(iq_i[PW-1:AMP_W]);
  assign p_si = s_w * i_w;
  assign p_cq = c_w * q_w;

  // unscaled path pre-shifted so the common renormalising shift restores it
  always_comb begin
    if (am_en_i) mix_d = MW'(p_si) + MW'(p_cq);
    else         mix_d = MW'(s_w) <<< (AMP_W - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mix_q <= '0;
    else if (run_i)  mix_q <= mix_d;
  end

  assign sh = mix_q >>> (AMP_W - 1);

  always_comb begin
    if (sh > HI)      clamped = HI;
    else if (sh < LO) clamped = LO;
    else              clamped = sh;
  end

  assign code_d = {~clamped[AMP_W-1], clamped[AMP_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_q <= '0;
    else if (!run_i) sample_q <= '0;
    else             sample_q <= code_d;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/nco_quad_mod.sv
`timescale 1ns/1ps
module nco_quad_mod #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ACC_W-1:0]   freq0_i,
  input  logic [ACC_W-1:0]   freq1_i,
  input  logic               fsel_i,
  input  logic [PH_W-1:0]    phase_i,
  input  logic [2*AMP_W-1:0] iq_i,
  input  logic               am_en_i,
  input  logic               acc_clr_i,
  input  logic               sleep_i,
  input  logic               sleep_cmd_i,
  output logic [AMP_W-1:0]   sample_o,
  output logic               valid_o
);
  localparam int LAT = 4;

  logic             run;
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  ph_q;
  logic [AMP_W-1:0] sin_q, cos_q;
  logic [LAT-1:0]   vld_q;

  assign run = ~(sleep_i | sleep_cmd_i);

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .clr_i   (acc_clr_i),
    .fsel_i  (fsel_i),
    .freq0_i (freq0_i),
    .freq1_i (freq1_i),
    .phase_i (phase_i),
    .acc_o   (acc_q),
    .ph_o    (ph_q)
  );

  nco_sincos_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .ph_i   (ph_q),
    .sin_o  (sin_q),
    .cos_o  (cos_q)
  );

  nco_am_scale #(.AMP_W(AMP_W)) u_am (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .am_en_i  (am_en_i),
    .iq_i     (iq_i),
    .sin_i    (sin_q),
    .cos_i    (cos_q),
    .sample_o (sample_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (!run) vld_q <= '0;
    else           vld_q <= {vld_q[LAT-2:0], 1'b1};
  end

  assign valid_o = vld_q[LAT-1];
endmodule

module nco_quad_mod_chk #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_i,
  input logic             sleep_cmd_i,
  input logic             acc_clr_i,
  input logic             fsel_i,
  input logic [ACC_W-1:0] freq0_i,
  input logic [ACC_W-1:0] freq1_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [AMP_W-1:0] sample_o,
  input logic             valid_o
);
  logic run;
  assign run = !(sleep_i || sleep_cmd_i);

  a_r1_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !acc_clr_i) |=> acc_i == $past(acc_i) + $past(fsel_i ? freq1_i : freq0_i));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_clr_i |=> acc_i == '0);

  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !acc_clr_i) |=> $stable(acc_i));

  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (sample_o == '0 && !valid_o));

  a_r6_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sample_o != '0);

  a_r9_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(run));
endmodule

bind nco_quad_mod nco_quad_mod_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_i     (sleep_i),
  .sleep_cmd_i (sleep_cmd_i),
  .acc_clr_i   (acc_clr_i),
  .fsel_i      (fsel_i),
  .freq0_i     (freq0_i),
  .freq1_i     (freq1_i),
  .acc_i       (acc_q),
  .sample_o    (sample_o),
  .valid_o     (valid_o)
);

// File: tb/nco_quad_mod_bench.sv
`timescale 1ns/1ps
module nco_quad_mod_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fw0, fw1;
  logic        fsel;
  logic [11:0] ph;
  logic [19:0] iq;
  logic        am, clr, slp, slpc;
  logic [9:0]  smp;
  logic        vld;

  always #2 clk = ~clk;

  nco_quad_mod u_nco_quad_mod (
    .clk_i (clk), .rst_ni (rst_n), .freq0_i (fw0), .freq1_i (fw1), .fsel_i (fsel),
    .phase_i (ph), .iq_i (iq), .am_en_i (am), .acc_clr_i (clr), .sleep_i (slp),
    .sleep_cmd_i (slpc), .sample_o (smp), .valid_o (vld)
  );

  int          checks = 0, failures = 0;
  bit          done = 0;
  logic [31:0] macc;
  int          n, w;
  logic [31:0] hist [8];
  logic [11:0] phist [8];
  logic        amh [8];
  logic [19:0] iqh [8];
  string       tag;

  localparam real PI = 3.14159265358979323846;

  function automatic real exp_code(logic [31:0] a, logic [11:0] p_off, logic ame, logic [19:0] iqv);
    int  p, ii, qq;
    real th, s, c, v;
    p  = (int'(a[31:20]) + int'(p_off)) % 4096;
    th = 2.0 * PI * (real'(p) + 0.5) / 4096.0;
    s  = 511.0 * $sin(th);
    c  = 511.0 * $cos(th);
    if (!ame) v = s;
    else begin
      ii = $signed(iqv[9:0]);
      qq = $signed(iqv[19:10]);
      v  = (s * real'(ii) + c * real'(qq)) / 512.0;
    end
    if (v > 511.0)  v = 511.0;
    if (v < -511.0) v = -511.0;
    return 512.0 + v;
  endfunction

  task automatic chk(bit ok, string t, string what, real act, real expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", t, what, act, expv);
    end
  endtask

  task automatic model_reset();
    macc = '0; n = 0; w = 0;
    foreach (hist[i]) hist[i] = '0;
  endtask

  task automatic tick();
    bit  act;
    real e, d, tol;
    @(posedge clk);
    act = !(slp || slpc);
    if (clr)      macc = '0;
    else if (act) macc = macc + (fsel ? fw1 : fw0);
    if (act) begin
      n++; w++;
      phist[n & 7] = ph; amh[n & 7] = am; iqh[n & 7] = iq;
    end else w = 0;
    hist[n & 7] = macc;
    @(negedge clk);
    if (!act) begin
      chk(smp == '0, "R8", "sample while asleep", real'(smp), 0.0);
      chk(vld == 1'b0, "R8", "valid while asleep", real'(vld), 0.0);
    end else if (w < 4) begin
      chk(vld == 1'b0, "R9", "valid before fill", real'(vld), 0.0);
    end else begin
      chk(vld == 1'b1, "R9", "valid after fill", real'(vld), 1.0);
      e   = exp_code(hist[(n - 4) & 7], phist[(n - 3) & 7], amh[(n - 1) & 7], iqh[(n - 1) & 7]);
      tol = amh[(n - 1) & 7] ? 4.5 : 1.5;
      d   = real'(smp) - e;
      if (d < 0.0) d = -d;
      chk(d <= tol, tag, "sample", real'(smp), e);
    end
  endtask

  task automatic sweep(int stp);
    for (int p = 0; p < 4096; p += stp) begin
      ph = 12'(p);
      tick();
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(smp == '0, "R10", "sample in reset", real'(smp), 0.0);
    chk(vld == 1'b0, "R10", "valid in reset", real'(vld), 0.0);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; fw0 = '0; fw1 = '0; fsel = 1'b0; ph = '0; iq = '0;
    am = 1'b0; clr = 1'b0; slp = 1'b0; slpc = 1'b0; tag = "R4";
    @(negedge clk);
    hold_reset();

    // R9: fill after reset, then R4 full sweep; iq nonzero must be ignored
    iq = {10'sd300, -10'sd200};
    tag = "R4"; sweep(1);
    // R5: pure cosine via Q, then mixed pairs
    am = 1'b1; iq = {10'sd511, 10'sd0};  tag = "R5"; sweep(1);
    iq = {10'sd362, 10'sd362};           sweep(3);
    iq = {10'sd200, -10'sd300};          sweep(5);
    // R6: saturating pairs
    iq = {10'sd511, 10'sd511};           tag = "R6"; sweep(7);
    iq = {-10'sd512, -10'sd512};         sweep(11);
    am = 1'b0; iq = '0; ph = '0;

    // R1: each tuning word alone, with carries and wrap
    clr = 1'b1; tick(); clr = 1'b0;
    fw0 = 32'h0400_000D; fw1 = 32'hF123_4567; tag = "R1";
    fsel = 1'b0; repeat (100) tick();
    fsel = 1'b1; repeat (100) tick();
    // R2: select toggling each few cycles
    tag = "R2";
    for (int i = 0; i < 200; i++) begin
      fsel = (i % 7) < 3;
      tick();
    end
    // R3: fixed and moving phase offsets while accumulating
    tag = "R3"; fsel = 1'b0; ph = 12'd1234; repeat (60) tick();
    for (int i = 0; i < 150; i++) begin
      ph = ph + 12'd37;
      tick();
    end
    // R7: clear pulse mid-stream
    tag = "R7"; clr = 1'b1; tick(); clr = 1'b0; repeat (30) tick();
    // R8: pin sleep, then command sleep with clear during sleep
    tag = "R8"; fsel = 1'b1; am = 1'b1; iq = {10'sd100, 10'sd400};
    slp = 1'b1; repeat (6) tick(); slp = 1'b0; repeat (20) tick();
    slpc = 1'b1; repeat (3) tick(); clr = 1'b1; tick(); clr = 1'b0; repeat (2) tick();
    slpc = 1'b0; tag = "R7"; repeat (20) tick();
    // R10: reset in mid-stream, then refill
    hold_reset();
    tag = "R10"; repeat (30) tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule